// File: doc/BRIEF.md
# Fixed-Point Sine/Cosine Rotator

This block produces the cosine and the sine of an angle from a single run of an iterative shift-and-add rotation. It has no multiplier. The angle is a binary fraction of a full turn, so any input value is already inside one revolution. Before the iterations start, the block folds the angle into the half-plane where the rotation converges. If the fold moved the angle by half a turn, the signs of both results are flipped at the end.

The starting vector is a pair of input ports, so the caller picks the initial x and y. The usual setting is x at the reciprocal of the rotation gain and y at zero. With that setting the outputs are cos and sin in Q1.15 and no scaling is needed afterwards. Any other seed vector is rotated by the same angle. To use the block, present the angle and seeds, pulse `start`, and wait for `done`. One micro-rotation is done per clock.

Top module: `cordic_sincos`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both results read 0.
- R2: `angle` is unsigned and a full turn equals 2^AW. For every angle the results match 32767·cos and 32767·sin of 2π·angle/2^AW to within 20 LSB when the seeds are x = 19898 and y = 0.
- R3: The results are signed Q1.15 values. They saturate to the range −32768..32767, so angle 0 gives a cosine of 32767 rather than wrapping.
- R4: A `start` pulse seen while `busy` is 0 sets `busy` to 1 and clears `done` at that clock edge. Exactly ITERS clock edges later, `busy` falls and `done` rises.
- R5: Once `done` is set, it stays at 1 and both results stay unchanged until the next accepted `start`.
- R6: A `start` pulse while `busy` is 1 has no effect. It does not change the result and does not change when `done` rises.
- R7: The results equal the seed vector (x_seed, y_seed) rotated by the angle and multiplied by the rotation gain G = Π sqrt(1+2^−2i) over the ITERS steps, within 20 LSB.
- R8: The two top angle bits select the quadrant (00 first, 01 second, 10 third, 11 fourth). For the second and third quadrants the angle is moved by half a turn and the signs of both results are negated. This gives correct results at the quadrant boundaries 0, 2^(AW−2), 2^(AW−1), 3·2^(AW−2) and at 2^AW−1.
- R9: The angle and the seeds are sampled only at the accepted `start` edge. Changing them while `busy` is 1 does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation when idle |
| angle | input | AW | Angle, full turn = 2^AW |
| x_seed | input | DW | Initial x of the rotated vector (Q1.15) |
| y_seed | input | DW | Initial y of the rotated vector (Q1.15) |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | Results valid, held until next start |
| cos_out | output | DW | Rotated x (cosine with default seeds) |
| sin_out | output | DW | Rotated y (sine with default seeds) |

## Verification
The bench builds the block with its default parameters: DW = 16, AW = 16 and ITERS = 16. The 16-bit angle width makes every quadrant and every boundary angle directly reachable. The full 16-iteration run makes both the exact latency and the saturation of a full-scale cosine at angle 0 and at half a turn visible. Random angles and random seed vectors are compared against a real-valued rotation computed in the bench. Directed runs then disturb `start`, the angle and the seeds in the middle of a computation.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Arctangent of 2^-i in units where a full turn is 2^16, rounded.
  function automatic int atan_turn16(input int i);
    case (i)
      0:  return 8192;
      1:  return 4836;
      2:  return 2555;
      3:  return 1297;
      4:  return 651;
      5:  return 326;
      6:  return 163;
      7:  return 81;
      8:  return 41;
      9:  return 20;
      10: return 10;
      11: return 5;
      12: return 3;
      13: return 1;
      14: return 1;
      default: return 0;
    endcase
  endfunction

  // Same constant rescaled to an angle word of aw bits.
  function automatic int atan_step(input int i, input int aw);
    int v;
    v = atan_turn16(i);
    if (aw >= 16) return v <<< (aw - 16);
    else          return v >>> (16 - aw);
  endfunction

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold #(
  parameter int AW = 16
) (
  input  logic [AW-1:0]        angle_i,
  output logic signed [AW-1:0] z_o,
  output logic                 flip_o
);
  // Quadrants two and three are moved by half a turn into [-1/4, +1/4).
  always_comb begin
    flip_o = angle_i[AW-1] ^ angle_i[AW-2];
    z_o    = {angle_i[AW-1] ^ flip_o, angle_i[AW-2:0]};
  end
endmodule

// File: rtl/cordic_rot.sv
module cordic_rot
  import cordic_pkg::*;
#(
  parameter int XW = 22,
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [AW-1:0] z_i,
  input  logic [CW-1:0]        idx_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [AW-1:0] z_o
);
  logic signed [XW-1:0] xs, ys;
  logic signed [AW-1:0] step;
  logic                 ccw;

  always_comb begin
    xs   = x_i >>> idx_i;
    ys   = y_i >>> idx_i;
    step = AW'(atan_step(int'(idx_i), AW));
    ccw  = ~z_i[AW-1];
    if (ccw) begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - step;
    end else begin
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + step;
    end
  end
endmodule

// File: rtl/cordic_out.sv
module cordic_out #(
  parameter int XW = 22,
  parameter int DW = 16,
  parameter int FB = 4
) (
  input  logic signed [XW-1:0] v_i,
  input  logic                 neg_i,
  output logic signed [DW-1:0] q_o
);
  localparam logic signed [XW:0] QMAX = XW'(2 ** (DW - 1) - 1);
  localparam logic signed [XW:0] QMIN = -(XW + 1)'(2 ** (DW - 1));

  logic signed [XW:0] ext, sgn, scl;

  always_comb begin
    ext = {v_i[XW-1], v_i};
    sgn = neg_i ? -ext : ext;
    scl = sgn >>> FB;
    if (scl > QMAX)      q_o = QMAX[DW-1:0];
    else if (scl < QMIN) q_o = QMIN[DW-1:0];
    else                 q_o = scl[DW-1:0];
  end
endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int ITERS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        angle,
  input  logic [DW-1:0]        x_seed,
  input  logic [DW-1:0]        y_seed,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] cos_out,
  output logic signed [DW-1:0] sin_out
);
  localparam int FB   = 4;
  localparam int XW   = DW + 2 + FB;
  localparam int CW   = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  logic signed [XW-1:0] x_q, y_q, x_n, y_n;
  logic signed [AW-1:0] z_q, z_n, fold_z;
  logic [CW-1:0]        cnt;
  logic                 flip_q, fold_flip;
  logic                 accept, last_step;
  logic signed [DW-1:0] cos_n, sin_n;

  assign accept    = start && !busy;
  assign last_step = busy && (cnt == LAST);

  cordic_fold #(.AW(AW)) u_fold (
    .angle_i (angle),
    .z_o     (fold_z),
    .flip_o  (fold_flip)
  );

  cordic_rot #(.XW(XW), .AW(AW), .CW(CW)) u_rot (
    .x_i   (x_q),
    .y_i   (y_q),
    .z_i   (z_q),
    .idx_i (cnt),
    .x_o   (x_n),
    .y_o   (y_n),
    .z_o   (z_n)
  );

  cordic_out #(.XW(XW), .DW(DW), .FB(FB)) u_out_c (
    .v_i   (x_n),
    .neg_i (flip_q),
    .q_o   (cos_n)
  );

  cordic_out #(.XW(XW), .DW(DW), .FB(FB)) u_out_s (
    .v_i   (y_n),
    .neg_i (flip_q),
    .q_o   (sin_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      cnt     <= '0;
      flip_q  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cos_out <= '0;
      sin_out <= '0;
    end else if (accept) begin
      x_q    <= XW'(signed'(x_seed)) <<< FB;
      y_q    <= XW'(signed'(y_seed)) <<< FB;
      z_q    <= fold_z;
      flip_q <= fold_flip;
      cnt    <= '0;
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
      cnt <= cnt + 1'b1;
      if (last_step) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        cos_out <= cos_n;
        sin_out <= sin_n;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !done); // R1
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy && !done); // R4
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(cos_out) && $stable(sin_out)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt != LAST) |=> busy && (cnt == $past(cnt) + 1'b1)); // R6
  AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (fold_z[AW-1] == fold_z[AW-2])); // R8
  AST_Z_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (z_q[AW-1] == z_q[AW-2])); // R8
endmodule

// File: tb/sim_cordic_sincos.sv
`timescale 1ns/1ps
module sim_cordic_sincos;
  localparam int DW = 16, AW = 16, ITERS = 16, TOL = 20;
  localparam int KX = 19898;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] angle = '0;
  logic [DW-1:0] x_seed = '0, y_seed = '0;
  logic busy, done;
  logic signed [DW-1:0] cos_out, sin_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cordic_sincos #(.DW(DW), .AW(AW), .ITERS(ITERS)) u0 (
    .clk, .rst_n, .start, .angle, .x_seed, .y_seed,
    .busy, .done, .cos_out, .sin_out
  );

  function automatic real gain();
    real g = 1.0;
    for (int i = 0; i < ITERS; i++) g = g * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    return g;
  endfunction

  function automatic int clampq(real v);
    int r = $rtoi(v < 0.0 ? v - 0.5 : v + 0.5);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int exp_x(int a, int xs, int ys);
    real th = 2.0 * 3.14159265358979 * a / 65536.0;
    return clampq(gain() * (xs * $cos(th) - ys * $sin(th)));
  endfunction

  function automatic int exp_y(int a, int xs, int ys);
    real th = 2.0 * 3.14159265358979 * a / 65536.0;
    return clampq(gain() * (xs * $sin(th) + ys * $cos(th)));
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic chk_near(string tag, int act, int expv);
    int d = act - expv;
    chk((d <= TOL) && (d >= -TOL), tag, act, expv);
  endtask

  // Runs one computation; disturb > 0 pulses start and scrambles inputs at that cycle.
  task automatic run(int a, int xs, int ys, int disturb, string tag);
    int n = 0;
    @(negedge clk);
    angle = AW'(a); x_seed = DW'(xs); y_seed = DW'(ys); start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    chk(busy && !done, "R4 busy after start", {busy, done}, 2);
    while (!done && n < 100) begin
      if (disturb > 0 && n == disturb) begin
        start = 1'b1; angle = angle + 16'h3000;
        x_seed = 16'h1234; y_seed = 16'h4321;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(n - 1 == ITERS, "R4 latency", n - 1, ITERS);
    chk_near({tag, " cos"}, cos_out, exp_x(a, $signed(16'(xs)), $signed(16'(ys))));
    chk_near({tag, " sin"}, sin_out, exp_y(a, $signed(16'(xs)), $signed(16'(ys))));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int hc, hs;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 flags", {busy, done}, 0);
    chk(cos_out == 0 && sin_out == 0, "R1 results", cos_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 quadrant boundaries, R3 saturation at 0 and half turn
    run(0, KX, 0, 0, "R3 angle0");
    chk(cos_out == 32767, "R3 saturate cos", cos_out, 32767);
    run(16384, KX, 0, 0, "R8 quarter");
    run(32768, KX, 0, 0, "R8 half");
    chk(cos_out <= -32747, "R3 negative full scale", cos_out, -32768);
    run(49152, KX, 0, 0, "R8 three-quarter");
    run(65535, KX, 0, 0, "R8 last");
    run(16383, KX, 0, 0, "R8 below quarter");
    run(16385, KX, 0, 0, "R8 above quarter");
    run(49151, KX, 0, 0, "R8 below 3q");

    // R5 hold
    hc = cos_out; hs = sin_out;
    repeat (6) @(negedge clk);
    chk(done == 1'b1, "R5 done held", done, 1);
    chk(cos_out == hc && sin_out == hs, "R5 results held", cos_out, hc);

    // R6 and R9: disturbance mid-run
    run(8000, KX, 0, 5, "R6 R9 disturbed");
    run(40000, KX, 0, 12, "R6 R9 disturbed late");

    // R2 random angles, default seeds
    for (int k = 0; k < 40; k++) run($urandom_range(0, 65535), KX, 0, 0, "R2 random");

    // R7 random seed vectors
    for (int k = 0; k < 20; k++)
      run($urandom_range(0, 65535), $urandom_range(0, 18000) - 9000,
          $urandom_range(0, 18000) - 9000, 0, "R7 seeds");
    run(5000, 0, KX, 0, "R7 swapped seed");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule